// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a serial slave that lets an external controller read and write a bank of thirty-two 8-bit configuration registers. The controller pulls an active-low select line low, toggles a serial clock, and sends an instruction byte first. That byte holds the transfer direction, a burst length of one to four bytes, and a 5-bit starting address. The data bytes follow. The port steps the register address by itself after each byte, and the address wraps from 31 back to 0.

Register 0 also configures the port. Bit 7 of register 0 selects three-wire operation: read data then leaves on the shared data line, and the dedicated output line stays undriven. With bit 7 clear the port runs four-wire: read data leaves on the dedicated output line, and the shared line stays input-only. Bit 6 of register 0 selects least-significant-bit-first framing for both the instruction byte and the data bytes. The default is most-significant-bit first.

The serial pins are sampled with the block's own system clock through a synchronizer. The serial clock must therefore run several times slower than the system clock. High-impedance is expressed through output-enable ports, and the pad ring builds the tri-state buffers from these. All thirty-two registers are presented in parallel to the rest of the chip.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every register reads 0x00, both output enables are low, the port is in four-wire mode and the bit order is MSB first.
- R2: The instruction byte is taken from the first eight rising serial clock edges after select goes low. Its bit 7 is the direction (1 = read, 0 = write), bits 6:5 hold the byte count minus one (00 = 1 byte through 11 = 4 bytes), and bits 4:0 hold the start address.
- R3: Input bits are captured on rising serial clock edges. Read data changes only after falling edges, so a read bit stays stable across the rising edge that follows it.
- R4: In a burst, byte i goes to address (start + i) modulo 32, so the address wraps from 31 to 0.
- R5: A written register takes its new value as soon as the eighth bit of its byte has been received, while select is still low.
- R6: In four-wire mode (register 0 bit 7 = 0), a read returns the addressed register contents on the dedicated output with its enable high, and the shared line's enable stays low.
- R7: In three-wire mode (register 0 bit 7 = 1), a read returns the data on the shared line with its enable high, and the dedicated output's enable stays low.
- R8: With register 0 bit 6 = 1, the instruction byte and the data bytes are shifted least significant bit first. The new order takes effect from the byte after the one that wrote it.
- R9: While select is high, neither output enable is asserted.
- R10: Raising select in the middle of a byte discards the partial byte, leaving every register unchanged. The next low select starts a fresh instruction byte.
- R11: Serial clock edges after the last byte of a burst, while select stays low, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| cs_n_i | input | 1 | Active-low select that frames a transfer |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side (three-wire reads) |
| sdio_oe_o | output | 1 | Drive enable for the shared data line |
| sdo_o | output | 1 | Dedicated serial data output (four-wire reads) |
| sdo_oe_o | output | 1 | Drive enable for the dedicated output |
| regs_o | output | 256 | All registers, register k at bits 8k+7:8k |

## Verification
The bench writes a four-byte burst starting at address 30. A port that does not wrap its address, or that wraps it wrongly, leaves registers 0 and 1 untouched or corrupts others. It drops select part-way through a data byte and also part-way through an instruction byte. A port that kept the bit counter alive would commit a stray write or misframe the next instruction. It clocks extra bytes after a one-byte write, which a port without a done state would spill into the neighbouring register. Random bursts keep rewriting register 0, so the bit order and the pin mode change in the middle of traffic. A design that latched the mode only once per transfer, or that drove the wrong pin, returns wrong read data or shows the wrong enable.

// File: rtl/scp_pkg.sv
// Package: shared constants and types for the serial configuration port.
// Assumes eight-bit registers and an eight-bit instruction byte.
package scp_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int BITCNT_W  = $clog2(BYTE_W);
    localparam int CFG_REG   = 0;
    localparam int BIDIR_BIT = 7;
    localparam int LSB_BIT   = 6;

    typedef enum logic [1:0] {
        PH_INSTR = 2'd0,
        PH_DATA  = 2'd1,
        PH_DONE  = 2'd2
    } phase_e;
endpackage

// File: rtl/scp_sync.sv
// Module: multi-stage synchronizer for a group of asynchronous pins.
// Each bit gets its own flop chain with a per-bit reset value.
// Assumes STAGES >= 2.
module scp_sync #(
    parameter int          N_SIG   = 3,
    parameter int          STAGES  = 2,
    parameter logic [31:0] RST_VAL = 32'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SIG-1:0] d_i,
    output logic [N_SIG-1:0] q_o
);
    for (genvar g = 0; g < N_SIG; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw pin through the chain of flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d_i[g]};
        end
        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/scp_regbank.sv
// Module: bank of byte-wide configuration registers with one write port,
// one combinational read port and a flat parallel view of all contents.
// Assumes at most one write strobe per cycle.
module scp_regbank
    import scp_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [BYTE_W-1:0]          wr_data_i,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    output logic [BYTE_W-1:0]          rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        // Load this register when the strobe addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_o[r*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en_i && (wr_addr_i == ADDR_W'(r)))
                regs_o[r*BYTE_W +: BYTE_W] <= wr_data_i;
        end
    end

    assign rd_data_o = regs_o[rd_addr_i*BYTE_W +: BYTE_W];

    // R11, R10: contents only move when a write strobe was issued.
    a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(regs_o));
endmodule

// File: rtl/scp_ctrl.sv
// Module: serial transfer controller. It detects serial clock edges on
// synchronized pins, assembles the instruction and data bytes, issues
// register writes and shifts read data out after falling edges.
// Assumes all inputs are already synchronized to clk.
module scp_ctrl
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s_i,
    input  logic              cs_n_s_i,
    input  logic              sdi_s_i,
    input  logic              lsb_first_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              out_bit_o,
    output logic              drive_en_o
);
    phase_e              phase;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   next_sh;
    logic [ADDR_W-1:0]   addr_q;
    logic [1:0]          left_q;
    logic                rw_q;
    logic                sclk_d;
    logic                out_q;
    logic                rise;
    logic                fall;
    logic                byte_end;
    logic [BITCNT_W-1:0] out_idx;

    assign rise     = sclk_s_i && !sclk_d;
    assign fall     = !sclk_s_i && sclk_d;
    assign next_sh  = lsb_first_i ? {sdi_s_i, shreg[BYTE_W-1:1]}
                                  : {shreg[BYTE_W-2:0], sdi_s_i};
    assign byte_end = rise && !cs_n_s_i && (phase != PH_DONE)
                      && (bit_cnt == BITCNT_W'(BYTE_W-1));
    assign out_idx  = lsb_first_i ? bit_cnt : BITCNT_W'(BYTE_W-1) - bit_cnt;

    assign wr_en_o    = byte_end && (phase == PH_DATA) && !rw_q;
    assign wr_data_o  = next_sh;
    assign addr_o     = addr_q;
    assign out_bit_o  = out_q;
    assign drive_en_o = (phase == PH_DATA) && rw_q && !cs_n_s_i;

    // Track the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s_i;
    end

    // Frame state: shift bits, decode the instruction, step the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            shreg   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            rw_q    <= 1'b0;
        end else if (cs_n_s_i) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
        end else if (rise && phase != PH_DONE) begin
            shreg   <= next_sh;
            bit_cnt <= bit_cnt + 1'b1;
            if (byte_end) begin
                if (phase == PH_INSTR) begin
                    rw_q   <= next_sh[7];
                    left_q <= next_sh[6:5];
                    addr_q <= next_sh[ADDR_W-1:0];
                    phase  <= PH_DATA;
                end else begin
                    addr_q <= addr_q + 1'b1;
                    if (left_q == 2'd0) phase  <= PH_DONE;
                    else                left_q <= left_q - 1'b1;
                end
            end
        end
    end

    // Present the next read bit after each falling serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= 1'b0;
        else if (fall && !cs_n_s_i && phase == PH_DATA && rw_q)
            out_q <= rd_data_i[out_idx];
    end

    // R4: every committed byte advances the address by one, modulo 32.
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> (addr_q == $past(addr_q) + 1'b1));
    // R10: a high select always returns the framer to a fresh instruction.
    a_r10_abort_restart: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s_i |=> (phase == PH_INSTR && bit_cnt == '0));
    // R11: no write can issue once the burst has completed.
    a_r11_done_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) |-> !wr_en_o);
    // R3: read data moves only after a falling serial clock edge.
    a_r3_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(out_q));
endmodule

// File: rtl/serial_cfg_port.sv
// Module: top of the serial configuration port. It synchronizes the pins,
// runs the transfer controller, holds the register bank and steers read
// data onto the shared or dedicated data line.
// Assumes the serial clock is at most about 1/6 of clk.
module serial_cfg_port
    import scp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_i,
    input  logic                       cs_n_i,
    input  logic                       sdio_i,
    output logic                       sdio_o,
    output logic                       sdio_oe_o,
    output logic                       sdo_o,
    output logic                       sdo_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    logic [2:0]        pins_s;
    logic              sclk_s, cs_n_s, sdi_s;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic              out_bit, drive_en;
    logic              cfg_bidir, cfg_lsb;

    scp_sync #(
        .N_SIG  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(32'h2)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({sdio_i, cs_n_i, sclk_i}),
        .q_o  (pins_s)
    );
    assign sclk_s = pins_s[0];
    assign cs_n_s = pins_s[1];
    assign sdi_s  = pins_s[2];

    assign cfg_bidir = regs_o[CFG_REG*BYTE_W + BIDIR_BIT];
    assign cfg_lsb   = regs_o[CFG_REG*BYTE_W + LSB_BIT];

    scp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s_i   (sclk_s),
        .cs_n_s_i   (cs_n_s),
        .sdi_s_i    (sdi_s),
        .lsb_first_i(cfg_lsb),
        .rd_data_i  (rd_data),
        .addr_o     (addr),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data),
        .out_bit_o  (out_bit),
        .drive_en_o (drive_en)
    );

    scp_regbank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en),
        .wr_addr_i(addr),
        .wr_data_i(wr_data),
        .rd_addr_i(addr),
        .rd_data_o(rd_data),
        .regs_o   (regs_o)
    );

    assign sdio_o    = out_bit;
    assign sdo_o     = out_bit;
    assign sdio_oe_o = drive_en && cfg_bidir;
    assign sdo_oe_o  = drive_en && !cfg_bidir;

    // R9: neither line is driven while the port is deselected.
    a_r9_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> (!sdo_oe_o && !sdio_oe_o));
    // R6, R7: at most one line drives, and it matches the pin mode.
    a_r7_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdo_oe_o && sdio_oe_o));
    a_r6_dedicated_in_4wire: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o |-> !cfg_bidir);
endmodule

// File: tb/serial_cfg_port_tb_top.sv
module serial_cfg_port_tb_top;
    localparam int HALF = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         sdi = 1'b0;
    logic         sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [255:0] regs_o;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] mdl [32];

    always #10 clk = ~clk;

    serial_cfg_port dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (sclk),
        .cs_n_i   (cs_n),
        .sdio_i   (sdi),
        .sdio_o   (sdio_o),
        .sdio_oe_o(sdio_oe),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe),
        .regs_o   (regs_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] instr_byte(input logic rw, input int n, input logic [4:0] a);
        return {rw, 2'(n - 1), a};
    endfunction

    function automatic string read_tag();
        return mdl[0][7] ? "R7" : "R6";
    endfunction

    task automatic send_bit(input logic b, output logic o, output logic so,
                            output logic sio, output logic held);
        logic v;
        sdi = b;
        repeat (HALF) @(negedge clk);
        o   = mdl[0][7] ? sdio_o : sdo_o;
        so  = sdo_oe;
        sio = sdio_oe;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        v = mdl[0][7] ? sdio_o : sdo_o;
        held = (v === o);
        repeat (HALF - 2) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic shift_byte(input logic [7:0] v, input logic rd, output logic [7:0] got);
        logic lsb, bid, o, so, sio, h, oe_bad, hold_bad;
        lsb = mdl[0][6];
        bid = mdl[0][7];
        oe_bad = 1'b0;
        hold_bad = 1'b0;
        got = '0;
        for (int k = 0; k < 8; k++) begin
            int idx;
            idx = lsb ? k : 7 - k;
            send_bit(v[idx], o, so, sio, h);
            got[idx] = o;
            if (rd) begin
                if (bid ? !(sio && !so) : !(so && !sio)) oe_bad = 1'b1;
                if (!h) hold_bad = 1'b1;
            end
        end
        if (rd) begin
            chk({read_tag(), " enables"}, 32'(oe_bad), 32'd0);
            chk("R3 read bit held over rise", 32'(hold_bad), 32'd0);
        end
    endtask

    task automatic full_compare(input string tag);
        for (int r = 0; r < 32; r++)
            chk(tag, 32'(regs_o[r*8 +: 8]), 32'(mdl[r]));
    endtask

    task automatic run_xfer(input logic rw, input int n, input logic [4:0] a0,
                            input logic [31:0] wd, input int extra, input string tag);
        logic [7:0] got;
        logic [4:0] a;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        shift_byte(instr_byte(rw, n, a0), 1'b0, got);
        for (int i = 0; i < n; i++) begin
            a = a0 + 5'(i);
            if (rw) begin
                shift_byte(8'($urandom), 1'b1, got);
                chk({read_tag(), " read data"}, 32'(got), 32'(mdl[a]));
            end else begin
                shift_byte(wd[i*8 +: 8], 1'b0, got);
                mdl[a] = wd[i*8 +: 8];
                chk("R5 register updated before deselect", 32'(regs_o[a*8 +: 8]), 32'(mdl[a]));
            end
        end
        for (int e = 0; e < extra; e++) shift_byte(8'($urandom), 1'b0, got);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        chk("R9 enables low when deselected", {30'd0, sdo_oe, sdio_oe}, 32'd0);
        full_compare(tag);
    endtask

    task automatic abort_xfer(input logic [4:0] a0, input int instr_bits, input int data_bits);
        logic o, so, sio, h;
        logic [7:0] ib;
        ib = instr_byte(1'b0, 1, a0);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < instr_bits; k++) begin
            int idx;
            idx = mdl[0][6] ? k : 7 - k;
            send_bit(ib[idx], o, so, sio, h);
        end
        for (int k = 0; k < data_bits; k++) send_bit(1'b1, o, so, sio, h);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        full_compare("R10 partial byte discarded");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5EED_0017);
        for (int r = 0; r < 32; r++) mdl[r] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state.
        full_compare("R1 reset contents");
        chk("R1 enables after reset", {30'd0, sdo_oe, sdio_oe}, 32'd0);

        // R2: single write then single read.
        run_xfer(1'b0, 1, 5'd5, 32'h0000_00A5, 0, "R2 single write");
        run_xfer(1'b1, 1, 5'd5, 32'h0, 0, "R2 single read");

        // R4: burst wraps from 31 to 0 (register 0 keeps mode bits clear).
        run_xfer(1'b0, 4, 5'd30, 32'h44_15_22_11, 0, "R4 wrapping burst");
        run_xfer(1'b1, 4, 5'd30, 32'h0, 0, "R4 wrapping read");
        run_xfer(1'b0, 3, 5'd17, 32'h00_C3_B2_A1, 0, "R4 three bytes");

        // R11: bytes beyond the burst are ignored.
        run_xfer(1'b0, 1, 5'd9, 32'h0000_005A, 2, "R11 trailing bytes ignored");
        run_xfer(1'b0, 2, 5'd31, 32'h0000_0C0B, 1, "R11 trailing after wrap");

        // R10: abort mid data byte and mid instruction.
        abort_xfer(5'd5, 8, 4);
        abort_xfer(5'd6, 5, 0);
        run_xfer(1'b0, 1, 5'd6, 32'h0000_0066, 0, "R10 fresh instruction after abort");

        // R8: switch to LSB-first framing.
        run_xfer(1'b0, 1, 5'd0, 32'h0000_0040, 0, "R8 set lsb first");
        run_xfer(1'b0, 2, 5'd12, 32'h0000_3C81, 0, "R8 lsb write");
        run_xfer(1'b1, 2, 5'd12, 32'h0, 0, "R8 lsb read");

        // R7: three-wire, both orders, then back to four-wire MSB.
        run_xfer(1'b0, 1, 5'd0, 32'h0000_00C0, 0, "R7 three-wire lsb");
        run_xfer(1'b1, 3, 5'd11, 32'h0, 0, "R7 three-wire read");
        run_xfer(1'b0, 1, 5'd0, 32'h0000_0080, 0, "R7 three-wire msb");
        run_xfer(1'b1, 4, 5'd29, 32'h0, 0, "R7 three-wire wrap read");
        run_xfer(1'b0, 1, 5'd0, 32'h0000_0000, 0, "R6 back to four-wire");
        run_xfer(1'b1, 2, 5'd17, 32'h0, 0, "R6 four-wire read");

        // Random traffic, including mode changes through register 0.
        for (int t = 0; t < 70; t++) begin
            logic       rw;
            int         n;
            logic [4:0] a;
            rw = 1'($urandom);
            n  = 1 + int'($urandom % 4);
            a  = 5'($urandom);
            run_xfer(rw, n, a, $urandom, int'($urandom % 2), rw ? "R6 random read" : "R4 random write");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule